// File: doc/BRIEF.md
# Timed Pulse Sequence Transmitter

This block plays a list of timed pulse entries, held in a small local memory, out onto a single output pin. Each 32-bit entry holds two halves. Each half gives an output level and a duration counted in ticks of an external tick-enable input. The block fetches entries one at a time through a valid/ready read port. It drives each half for its duration and stops when it reaches a zero duration or runs past its memory window. When it stops it raises a one-cycle transmit-end pulse.

There are three ways to run it. In one-shot mode it stops at the end of the message. In continuous mode it restarts from address 0 every time it reaches the end. In wraparound mode the read pointer returns to 0 after the last word of the window, so software can refill entries that have already been sent. A programmable entry-count threshold pulse tells software when to refill. While no message is running, the pin shows a configured idle level, but only when idle drive is enabled.

The read request follows valid/ready rules. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen high at a clock edge. Exactly one request is outstanding at a time. The memory answers with a one-cycle `mem_rsp_valid`, which may come any number of cycles after acceptance. The block never applies back-pressure to a response.

Top module: `pulse_seq_tx`

## Requirements
- R1: After reset the state code is 0 (idle), no read request is made, both interrupt pulses are low, and the read pointer is 0.
- R2: An entry's low half (level bit 15, duration bits 14:0) is played first, then its high half (level bit 31, duration bits 30:16). Each half drives its level for exactly that many tick_en cycles while the state code is 1 (send), and pin_oe is high whenever the block is not idle.
- R3: In state 2 (read memory) the block requests the entry at its read pointer and holds the address stable until ready. After acceptance it is in state 4 (wait) with no request until mem_rsp_valid. Ticks are not counted during fetches, and the pin keeps its previous level.
- R4: A zero duration in either half ends the message. In one-shot mode the block returns to idle and irq_tx_end pulses for one cycle, in the first idle cycle.
- R5: With cfg_conti set, an end of message restarts fetching at address 0 with no irq_tx_end. Clearing cfg_conti lets the next end finish normally.
- R6: With cfg_wrap set, the read pointer advances from cfg_range-1 to 0.
- R7: With cfg_wrap clear, mem_empty is high exactly when the read pointer is at or beyond cfg_range. Reaching that point in state 2 ends the message as a zero duration does.
- R8: irq_tx_thr pulses for one cycle each time cfg_tx_lim further entries have been fully played (both halves) since start or since the last pulse. A limit of 0 disables the pulse.
- R9: While idle, pin_oe equals cfg_idle_en and pin_out is cfg_idle_lvl when enabled, otherwise 0. From a start until the first entry plays, pin_out shows cfg_idle_lvl.
- R10: rd_ptr_rst sets the read pointer to 0. A start without it resumes at the word after the entry that ended the previous message.
- R11: tx_start has an effect only when idle. A start while busy does not restart or extend the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Duration tick enable |
| tx_start | input | 1 | Start pulse |
| rd_ptr_rst | input | 1 | Read pointer reset pulse |
| cfg_conti | input | 1 | Continuous repeat mode |
| cfg_wrap | input | 1 | Wraparound window mode |
| cfg_range | input | ADDR_W+1 | Window size in words |
| cfg_tx_lim | input | LIM_W | Entry threshold (0 = off) |
| cfg_idle_lvl | input | 1 | Idle output level |
| cfg_idle_en | input | 1 | Drive pin while idle |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 2*(DUR_W+1) | Entry read from memory |
| pin_out | output | 1 | Output level |
| pin_oe | output | 1 | Output enable |
| tx_state | output | 3 | State code: 0 idle, 1 send, 2 read, 3 receive (unused), 4 wait |
| mem_empty | output | 1 | Read pointer past window (non-wrap) |
| irq_tx_end | output | 1 | Transmit-end pulse |
| irq_tx_thr | output | 1 | Threshold pulse |

## Verification
The hardest situation to reach is the threshold pulse arriving in wraparound mode while a refill is under way. That needs the pointer to have passed the window end several times, and the memory contents to change between two fetches of the same address. The bench gets there with a four-word window and a limit of three. It rewrites the window with end markers on the third threshold pulse, so the message ends on the tenth fetch. Random ready stalls, response delays and tick gaps run throughout, and a behavioural model checks every output on every cycle.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_READ = 3'd2,
    ST_RECV = 3'd3,
    ST_WAIT = 3'd4
  } pst_state_e;
endpackage

// File: rtl/pst_rdptr.sv
module pst_rdptr #(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic            cfg_wrap,
  input  logic [ADDR_W:0] cfg_range,
  output logic [ADDR_W:0] ptr,
  output logic            exhausted
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] inc;
  logic [PW-1:0] nxt;

  always_comb begin
    inc = ptr + PW'(1);
    // wrap back to window start after its last word
    nxt = (cfg_wrap && (inc == cfg_range)) ? '0 : inc;
  end

  assign exhausted = !cfg_wrap && (ptr >= cfg_range);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= nxt;
  end
endmodule

// File: rtl/pst_thr.sv
module pst_thr #(
  parameter int LIM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             entry_done,
  input  logic [LIM_W-1:0] lim,
  output logic             thr_pulse
);
  logic [LIM_W-1:0] cnt;
  logic [LIM_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + (LIM_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      thr_pulse <= 1'b0;
    end else begin
      thr_pulse <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (entry_done && (lim != '0)) begin
        if (cnt_inc >= {1'b0, lim}) begin
          cnt       <= '0;
          thr_pulse <= 1'b1;
        end else begin
          cnt <= cnt_inc[LIM_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/pst_timer.sv
module pst_timer #(
  parameter int DUR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);
  logic [DUR_W-1:0] cnt;

  assign expire = run && tick && (cnt == DUR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt <= '0;
    else if (load)                                cnt <= load_val;
    else if (run && tick && (cnt > DUR_W'(1)))    cnt <= cnt - DUR_W'(1);
  end
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
#(
  parameter int DUR_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_start,
  input  logic               cfg_conti,
  input  logic               cfg_idle_lvl,
  input  logic               exhausted,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [2*DUR_W+1:0] mem_rsp_data,
  input  logic               half_expire,
  output pst_state_e         st,
  output logic               lvl,
  output logic               req_valid,
  output logic               adv,
  output logic               restart,
  output logic               start_acc,
  output logic               entry_done,
  output logic               end_pulse,
  output logic               tmr_load,
  output logic [DUR_W-1:0]   tmr_val
);
  logic [DUR_W-1:0] lo_dur, hi_dur, hold_dur;
  logic             lo_lvl, hi_lvl, hold_lvl;
  logic             half, half_n, lvl_n, cap, end_ev;
  pst_state_e       st_n;

  assign lo_dur = mem_rsp_data[DUR_W-1:0];
  assign lo_lvl = mem_rsp_data[DUR_W];
  assign hi_dur = mem_rsp_data[2*DUR_W:DUR_W+1];
  assign hi_lvl = mem_rsp_data[2*DUR_W+1];

  assign req_valid = (st == ST_READ) && !exhausted;
  assign start_acc = (st == ST_IDLE) && tx_start;

  always_comb begin
    st_n       = st;
    lvl_n      = lvl;
    half_n     = half;
    end_ev     = 1'b0;
    adv        = 1'b0;
    entry_done = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = lo_dur;
    cap        = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (tx_start) begin
          st_n  = ST_READ;
          lvl_n = cfg_idle_lvl;
        end
      end
      ST_READ: begin
        if (exhausted) begin
          end_ev = 1'b1;
        end else if (mem_req_ready) begin
          adv  = 1'b1;
          st_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (lo_dur == '0) begin
            end_ev = 1'b1;
          end else begin
            st_n     = ST_SEND;
            lvl_n    = lo_lvl;
            tmr_load = 1'b1;
            tmr_val  = lo_dur;
            half_n   = 1'b0;
            cap      = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (half_expire) begin
          if (!half) begin
            if (hold_dur == '0) begin
              end_ev = 1'b1;
            end else begin
              lvl_n    = hold_lvl;
              tmr_load = 1'b1;
              tmr_val  = hold_dur;
              half_n   = 1'b1;
            end
          end else begin
            entry_done = 1'b1;
            st_n       = ST_READ;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (end_ev) st_n = cfg_conti ? ST_READ : ST_IDLE;
  end

  assign restart = end_ev && cfg_conti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lvl       <= 1'b0;
      half      <= 1'b0;
      hold_dur  <= '0;
      hold_lvl  <= 1'b0;
      end_pulse <= 1'b0;
    end else begin
      st        <= st_n;
      lvl       <= lvl_n;
      half      <= half_n;
      end_pulse <= end_ev && !cfg_conti;
      if (cap) begin
        hold_dur <= hi_dur;
        hold_lvl <= hi_lvl;
      end
    end
  end
endmodule

// File: rtl/pulse_seq_tx.sv
module pulse_seq_tx
  import pst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DUR_W  = 15,
  parameter int LIM_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               tx_start,
  input  logic               rd_ptr_rst,
  input  logic               cfg_conti,
  input  logic               cfg_wrap,
  input  logic [ADDR_W:0]    cfg_range,
  input  logic [LIM_W-1:0]   cfg_tx_lim,
  input  logic               cfg_idle_lvl,
  input  logic               cfg_idle_en,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [2*DUR_W+1:0] mem_rsp_data,
  output logic               pin_out,
  output logic               pin_oe,
  output logic [2:0]         tx_state,
  output logic               mem_empty,
  output logic               irq_tx_end,
  output logic               irq_tx_thr
);
  pst_state_e       st;
  logic             lvl, adv, restart, start_acc, entry_done;
  logic             tmr_load, half_expire, exhausted;
  logic [DUR_W-1:0] tmr_val;
  logic [ADDR_W:0]  ptr;

  pst_ctrl #(.DUR_W(DUR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_start     (tx_start),
    .cfg_conti    (cfg_conti),
    .cfg_idle_lvl (cfg_idle_lvl),
    .exhausted    (exhausted),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .half_expire  (half_expire),
    .st           (st),
    .lvl          (lvl),
    .req_valid    (mem_req_valid),
    .adv          (adv),
    .restart      (restart),
    .start_acc    (start_acc),
    .entry_done   (entry_done),
    .end_pulse    (irq_tx_end),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val)
  );

  pst_timer #(.DUR_W(DUR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .run     (st == ST_SEND),
    .tick    (tick_en),
    .expire  (half_expire)
  );

  pst_rdptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rd_ptr_rst || restart),
    .adv      (adv),
    .cfg_wrap (cfg_wrap),
    .cfg_range(cfg_range),
    .ptr      (ptr),
    .exhausted(exhausted)
  );

  pst_thr #(.LIM_W(LIM_W)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_acc),
    .entry_done(entry_done),
    .lim       (cfg_tx_lim),
    .thr_pulse (irq_tx_thr)
  );

  assign mem_req_addr = ptr[ADDR_W-1:0];
  assign mem_empty    = exhausted;
  assign tx_state     = st;
  assign pin_out      = (st == ST_IDLE) ? (cfg_idle_en & cfg_idle_lvl) : lvl;
  assign pin_oe       = (st != ST_IDLE) || cfg_idle_en;
endmodule

// File: rtl/pst_chk.sv
module pst_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_ptr_rst,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [2:0]        tx_state,
  input logic              pin_oe,
  input logic              mem_empty,
  input logic              irq_tx_end,
  input logic              irq_tx_thr
);
  // R3: a stalled request stays in place with the same address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !rd_ptr_rst) |=>
      (mem_req_valid && $stable(mem_req_addr)));

  // R3: nothing is requested while a response is awaited
  a_r3_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state == 3'd4) |-> !mem_req_valid);

  // R4: the end pulse marks the first idle cycle after activity
  a_r4_end_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_end |-> ((tx_state == 3'd0) && ($past(tx_state) != 3'd0)));

  // R2: pin is driven throughout a message
  a_r2_busy_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_state != 3'd0) |-> pin_oe);

  // R7: an exhausted window issues no request
  a_r7_empty_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_empty |-> !mem_req_valid);

  // R8: threshold pulse follows a cycle spent sending
  a_r8_thr_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_thr |-> ($past(tx_state) == 3'd1));
endmodule

bind pulse_seq_tx pst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_ptr_rst   (rd_ptr_rst),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .tx_state     (tx_state),
  .pin_oe       (pin_oe),
  .mem_empty    (mem_empty),
  .irq_tx_end   (irq_tx_end),
  .irq_tx_thr   (irq_tx_thr)
);

// File: tb/pulse_seq_tx_tb_top.sv
`timescale 1ns/1ps
module pulse_seq_tx_tb_top;
  localparam int AW = 6;
  localparam int DW = 15;
  localparam int LW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, tx_start = 1'b0, rd_ptr_rst = 1'b0;
  logic cfg_conti = 1'b0, cfg_wrap = 1'b0, cfg_idle_lvl = 1'b0, cfg_idle_en = 1'b0;
  logic [AW:0] cfg_range = 7'd16;
  logic [LW-1:0] cfg_tx_lim = '0;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic mem_req_valid, pin_out, pin_oe, mem_empty, irq_tx_end, irq_tx_thr;
  logic [AW-1:0] mem_req_addr;
  logic [2:0] tx_state;

  always #2.5 clk = ~clk;

  pulse_seq_tx #(.ADDR_W(AW), .DUR_W(DW), .LIM_W(LW)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] mem [64];
  int fetch_q[$];
  int n_end = 0, n_thr = 0;
  bit pend = 0;
  int paddr = 0, pdly = 0;

  // reference model state
  int m_st = 0, m_ptr = 0, m_cnt = 0, m_half = 0, m_lvl = 0;
  int m_hl = 0, m_hd = 0, m_thr = 0, m_end = 0, m_thrp = 0;

  function automatic logic [31:0] ent(int l0, int d0, int l1, int d1);
    return {l1[0], d1[14:0], l0[0], d0[14:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_exh();
    return (!cfg_wrap && m_ptr >= int'(cfg_range)) ? 1 : 0;
  endfunction

  // model step on each edge, using the inputs held since the last falling edge
  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend = 1; paddr = int'(mem_req_addr); pdly = $urandom % 3;
      fetch_q.push_back(int'(mem_req_addr));
    end
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_cnt = 0; m_half = 0; m_lvl = 0;
      m_hl = 0; m_hd = 0; m_thr = 0; m_end = 0; m_thrp = 0;
    end else begin
      int nptr, ev, dur;
      nptr = m_ptr; ev = 0; m_end = 0; m_thrp = 0;
      case (m_st)
        0: if (tx_start) begin m_st = 2; m_lvl = cfg_idle_lvl; m_thr = 0; end
        2: if (m_exh() != 0) ev = 1;
           else if (mem_req_ready) begin
             nptr = (m_ptr + 1) & 127;
             if (cfg_wrap && nptr == int'(cfg_range)) nptr = 0;
             m_st = 4;
           end
        4: if (mem_rsp_valid) begin
             dur = int'(mem_rsp_data[14:0]);
             if (dur == 0) ev = 1;
             else begin
               m_lvl = mem_rsp_data[15]; m_cnt = dur; m_half = 0;
               m_hl = mem_rsp_data[31]; m_hd = int'(mem_rsp_data[30:16]); m_st = 1;
             end
           end
        1: if (tick_en) begin
             if (m_cnt == 1) begin
               if (m_half == 0) begin
                 if (m_hd == 0) ev = 1;
                 else begin m_lvl = m_hl; m_cnt = m_hd; m_half = 1; end
               end else begin
                 m_st = 2;
                 if (cfg_tx_lim != 0) begin
                   if (m_thr + 1 >= int'(cfg_tx_lim)) begin m_thr = 0; m_thrp = 1; end
                   else m_thr++;
                 end
               end
             end else m_cnt--;
           end
        default: ;
      endcase
      if (ev != 0) begin
        if (cfg_conti) begin nptr = 0; m_st = 2; end
        else begin m_st = 0; m_end = 1; end
      end
      if (rd_ptr_rst) nptr = 0;
      m_ptr = nptr;
    end
  end

  // compare every cycle, away from both clock edges
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int e_pin, e_oe, e_req;
      e_pin = (m_st == 0) ? int'(cfg_idle_en & cfg_idle_lvl) : m_lvl;
      e_oe  = (m_st != 0 || cfg_idle_en) ? 1 : 0;
      e_req = (m_st == 2 && m_exh() == 0) ? 1 : 0;
      chk(int'(pin_out) == e_pin, (m_st == 0) ? "R9 pin_out" : "R2 pin_out", int'(pin_out), e_pin);
      chk(int'(pin_oe) == e_oe, "R9 pin_oe", int'(pin_oe), e_oe);
      chk(int'(tx_state) == m_st, "R3 tx_state", int'(tx_state), m_st);
      chk(int'(mem_req_valid) == e_req, "R3 mem_req_valid", int'(mem_req_valid), e_req);
      if (e_req != 0) chk(int'(mem_req_addr) == (m_ptr & 63), "R3 mem_req_addr", int'(mem_req_addr), m_ptr & 63);
      chk(int'(mem_empty) == m_exh(), "R7 mem_empty", int'(mem_empty), m_exh());
      chk(int'(irq_tx_end) == m_end, "R4 irq_tx_end", int'(irq_tx_end), m_end);
      chk(int'(irq_tx_thr) == m_thrp, "R8 irq_tx_thr", int'(irq_tx_thr), m_thrp);
      if (irq_tx_end) n_end++;
      if (irq_tx_thr) n_thr++;
    end
  end

  // memory responder and random ready / tick
  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (pdly == 0) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= mem[paddr]; pend = 0;
      end else pdly--;
    end
    mem_req_ready <= ($urandom % 3) != 0;
    tick_en <= ($urandom % 2) != 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic start_pulse();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic ptr_reset();
    @(negedge clk); rd_ptr_rst = 1'b1;
    @(negedge clk); rd_ptr_rst = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (tx_state != 3'd0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int e0, f0, thr_seen;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0] = ent(1, 3, 0, 2);
    mem[1] = ent(1, 1, 0, 4);
    mem[2] = ent(1, 2, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_state == 3'd0, "R1 state", int'(tx_state), 0);
    chk(!mem_req_valid && !irq_tx_end && !irq_tx_thr, "R1 quiet", int'(mem_req_valid), 0);
    chk(pin_oe == 1'b0, "R1 pin_oe", int'(pin_oe), 0);

    // one-shot, end marker in high half (R2, R4)
    cfg_idle_en = 1'b1; cfg_idle_lvl = 1'b0;
    e0 = n_end; f0 = fetch_q.size();
    start_pulse(); wait_idle();
    chk(n_end - e0 == 1, "R4 one end pulse", n_end - e0, 1);
    chk(fetch_q.size() - f0 == 3, "R2 fetch count", fetch_q.size() - f0, 3);

    // resume without pointer reset (R10)
    mem[3] = ent(0, 0, 0, 0);
    f0 = fetch_q.size();
    start_pulse(); wait_idle();
    chk(fetch_q[f0] == 3, "R10 resume addr", fetch_q[f0], 3);

    // pointer reset, plus a start while busy (R10, R11)
    ptr_reset();
    e0 = n_end; f0 = fetch_q.size();
    cfg_idle_lvl = 1'b1;
    start_pulse();
    repeat (6) @(negedge clk);
    start_pulse();
    wait_idle();
    chk(fetch_q[f0] == 0, "R10 reset addr", fetch_q[f0], 0);
    chk(n_end - e0 == 1, "R11 single end", n_end - e0, 1);
    chk(fetch_q.size() - f0 == 3, "R11 no extra fetch", fetch_q.size() - f0, 3);

    // non-wrap window exhaustion (R7)
    cfg_range = 7'd4;
    mem[2] = ent(0, 2, 1, 1);
    mem[3] = ent(1, 1, 0, 1);
    ptr_reset();
    e0 = n_end; f0 = fetch_q.size();
    start_pulse(); wait_idle();
    chk(mem_empty == 1'b1, "R7 empty after window", int'(mem_empty), 1);
    chk(fetch_q.size() - f0 == 4, "R7 stops at window", fetch_q.size() - f0, 4);
    chk(n_end - e0 == 1, "R7 end pulse", n_end - e0, 1);
    chk(n_thr == 0, "R8 limit zero silent", n_thr, 0);
    ptr_reset();
    @(negedge clk);
    chk(mem_empty == 1'b0, "R10 empty clears", int'(mem_empty), 0);

    // wraparound with threshold refill (R6, R8)
    cfg_wrap = 1'b1; cfg_tx_lim = 9'd3;
    e0 = n_end; f0 = fetch_q.size(); thr_seen = 0;
    start_pulse();
    do begin
      @(negedge clk);
      if (irq_tx_thr) begin
        thr_seen++;
        if (thr_seen == 3) for (int i = 0; i < 4; i++) mem[i] = '0;
      end
    end while (tx_state != 3'd0);
    repeat (3) @(negedge clk);
    chk(thr_seen == 3, "R8 threshold count", thr_seen, 3);
    chk(fetch_q[f0 + 4] == 0, "R6 wrap to zero", fetch_q[f0 + 4], 0);
    chk(fetch_q.size() - f0 == 10, "R6 fetch total", fetch_q.size() - f0, 10);
    chk(n_end - e0 == 1, "R4 wrap end", n_end - e0, 1);

    // continuous repeat (R5)
    cfg_wrap = 1'b0; cfg_tx_lim = '0; cfg_range = 7'd16;
    mem[0] = ent(1, 2, 0, 1);
    mem[1] = ent(0, 1, 1, 2);
    mem[2] = ent(0, 0, 0, 0);
    cfg_conti = 1'b1;
    ptr_reset();
    e0 = n_end; f0 = fetch_q.size();
    start_pulse();
    begin
      int zeros;
      zeros = 0;
      while (zeros < 3) begin
        @(negedge clk);
        zeros = 0;
        for (int i = f0; i < fetch_q.size(); i++) if (fetch_q[i] == 0) zeros++;
      end
    end
    chk(n_end == e0, "R5 no end while repeating", n_end - e0, 0);
    chk(fetch_q[f0 + 3] == 0, "R5 restart addr", fetch_q[f0 + 3], 0);
    cfg_conti = 1'b0;
    wait_idle();
    chk(n_end - e0 == 1, "R5 end after clear", n_end - e0, 1);

    // idle drive (R9)
    cfg_idle_en = 1'b1; cfg_idle_lvl = 1'b1;
    @(negedge clk);
    chk(pin_out == 1'b1 && pin_oe == 1'b1, "R9 idle high", int'(pin_out), 1);
    cfg_idle_en = 1'b0;
    @(negedge clk);
    chk(pin_oe == 1'b0 && pin_out == 1'b0, "R9 idle off", int'(pin_oe), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule